// File: doc/BRIEF.md
# Low-Order Interleaved Byte Bank Selector

This block sits between a CPU-side request stream and a row of byte-wide memory banks. It spreads the physical byte address space across the banks by low-order interleaving. The lowest address bits name the bank, and the next physical bits give the location inside that bank. Consecutive bytes therefore land in consecutive banks, so one aligned 8-byte access reaches eight neighbouring banks in the same cycle over a 64-bit data path.

Requests arrive on a valid/ready stream. Each request gives an address, a read/write flag, a width flag (one byte or eight bytes) and write data. Each accepted request produces exactly one response beat, one clock later. The beat carries the read data and two error flags. The response side has its own ready. The block holds a single response register, so it accepts a new request only when that register is empty or is being drained in the same cycle. While the response is not taken, the block stalls the request side and keeps the response beat steady. The bank enables, the write strobe and the shared in-bank offset are brought out so the bank selection can be observed. The banks are small parameterised byte arrays.

Top module: `byte_bank_interleaver`

## Requirements
- R1: An accepted request with any of address bits 31..28 set enables no bank. Its response has the range error flag at 1, the alignment error flag at 0 and data of zero. The range check takes priority over the alignment check.
- R2: Bank number = address bits 5..0. Every bank sees the same offset, address bits 27..6, on the shared offset output. Inside the modelled bank only the low log2(depth) offset bits (default 4, address bits 9..6) pick the entry, so offsets that differ only above those bits alias.
- R3: An accepted in-range single-byte request (width flag 0) asserts exactly one bank enable, at the addressed bank. A write stores write-data bits 7..0. A read returns the byte in response bits 7..0, with bits 63..8 zero.
- R4: An accepted in-range 8-byte request (width flag 1) with address bits 2..0 at zero enables exactly the eight banks from the addressed bank upward. Lane k (data bits 8k+7..8k, lane 0 least significant) pairs with bank (addressed bank + k) for both writes and reads.
- R5: An accepted in-range 8-byte request with address bits 2..0 not all zero enables no bank and writes nothing. Its response has the alignment error flag at 1, the range error flag at 0 and data of zero.
- R6: In a cycle with no accepted request, no bank enable is asserted.
- R7: Every accepted request produces one response beat in the following cycle. Write and error responses carry data of zero.
- R8: Request ready equals (response not valid) or (response ready). While the response is valid and not ready, the response beat (valid, data, both error flags) holds unchanged into the next cycle.
- R9: After reset the response valid is 0 and every bank entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = single byte |
| req_wdata | input | 64 | Write data, lane 0 in bits 7..0 |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response consumer can take the beat |
| rsp_rdata | output | 64 | Read data, lane 0 in bits 7..0 |
| rsp_err_range | output | 1 | Address was outside the physical range |
| rsp_err_align | output | 1 | 8-byte access was not 8-byte aligned |
| bank_en | output | 64 | Per-bank enable, bit b for bank b |
| bank_we | output | 1 | Write strobe shared by all enabled banks |
| bank_offset | output | 22 | In-bank offset shared by all banks |

## Verification
The bench aims 8-byte accesses at the top group of banks (base 56) and at bank 0. A lane rotation or an off-by-one group decode would then scramble bytes or enable a ninth bank. It mixes misaligned wide requests with out-of-range ones, including an address that is both. A wrong priority, or an error that still enables banks, shows up as a corrupted later readback or a wrong flag. An alias pair one offset wrap apart checks that the in-bank index uses the correct address bits. Response stalls check that the data does not change while held, and that a request is not accepted into a full response register.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int ADDR_W = 32;
  localparam int PHYS_W = 28;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_BYTE,
    ACC_WIDE,
    ACC_BAD_RANGE,
    ACC_BAD_ALIGN
  } acc_kind_t;
endpackage

// File: rtl/ilv_decode.sv
module ilv_decode
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int LANES     = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int LANE_W   = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 wide,
  input  logic [ADDR_W-1:0]    addr,
  output acc_kind_t            kind,
  output logic [NUM_BANKS-1:0] en
);
  logic [SEL_W-1:0] sel;
  logic             out_of_range;
  logic             misaligned;

  assign sel          = addr[SEL_W-1:0];
  assign out_of_range = |addr[ADDR_W-1:PHYS_W];
  assign misaligned   = wide && (addr[LANE_W-1:0] != '0);

  always_comb begin
    if (!fire)             kind = ACC_IDLE;
    else if (out_of_range) kind = ACC_BAD_RANGE;
    else if (misaligned)   kind = ACC_BAD_ALIGN;
    else if (wide)         kind = ACC_WIDE;
    else                   kind = ACC_BYTE;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
    localparam logic [SEL_W-1:0]        BANK_ID  = SEL_W'(b);
    localparam logic [SEL_W-LANE_W-1:0] GROUP_ID = BANK_ID[SEL_W-1:LANE_W];
    assign en[b] = ((kind == ACC_BYTE) && (sel == BANK_ID)) ||
                   ((kind == ACC_WIDE) && (sel[SEL_W-1:LANE_W] == GROUP_ID));
  end

  assert_idle_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (en == '0));
  assert_byte_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wide && !out_of_range) |-> ($countones(en) == 1 && en[sel]));
  assert_wide_eight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wide && !out_of_range && addr[LANE_W-1:0] == '0) |-> ($countones(en) == LANES));
  assert_range_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_of_range) |-> (en == '0));
  assert_align_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wide && addr[LANE_W-1:0] != '0) |-> (en == '0));
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte
);
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (en && we) begin
      cells[idx] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rbyte <= '0;
    else if (en && !we) rbyte <= cells[idx];
  end
endmodule

// File: rtl/ilv_gather.sv
module ilv_gather
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 64,
  parameter int LANES     = 8,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int LANE_W   = $clog2(LANES),
  localparam int DATA_W   = LANES * BYTE_W
) (
  input  logic [NUM_BANKS*BYTE_W-1:0] bank_q,
  input  logic [SEL_W-1:0]            sel_q,
  input  logic                        wide_q,
  input  logic                        read_q,
  output logic [DATA_W-1:0]           rdata
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] src;
    assign src = wide_q ? {sel_q[SEL_W-1:LANE_W], LANE_W'(k)} : sel_q;
    if (k == 0) begin : g_lsb
      assign rdata[BYTE_W-1:0] = read_q ? bank_q[src*BYTE_W +: BYTE_W] : '0;
    end else begin : g_upper
      assign rdata[k*BYTE_W +: BYTE_W] =
        (read_q && wide_q) ? bank_q[src*BYTE_W +: BYTE_W] : '0;
    end
  end
endmodule

// File: rtl/byte_bank_interleaver.sv
module byte_bank_interleaver
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS  = 64,
  parameter int LANES      = 8,
  parameter int BANK_DEPTH = 16,
  localparam int SEL_W     = $clog2(NUM_BANKS),
  localparam int OFF_W     = PHYS_W - SEL_W,
  localparam int IDX_W     = $clog2(BANK_DEPTH),
  localparam int DATA_W    = LANES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 req_wide,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err_range,
  output logic                 rsp_err_align,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic                 bank_we,
  output logic [OFF_W-1:0]     bank_offset
);
  logic                        fire;
  acc_kind_t                   kind;
  logic [NUM_BANKS*BYTE_W-1:0] bank_q;
  logic [SEL_W-1:0]            sel_q;
  logic                        wide_q;
  logic                        read_q;

  assign req_ready   = !rsp_valid || rsp_ready;
  assign fire        = req_valid && req_ready;
  assign bank_we     = req_write;
  assign bank_offset = req_addr[PHYS_W-1:SEL_W];

  ilv_decode #(.NUM_BANKS(NUM_BANKS), .LANES(LANES)) u_decode (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .wide (req_wide),
    .addr (req_addr),
    .kind (kind),
    .en   (bank_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BYTE_W-1:0] wbyte;
    assign wbyte = req_wide ? req_wdata[(b % LANES)*BYTE_W +: BYTE_W]
                            : req_wdata[BYTE_W-1:0];
    ilv_bank #(.DEPTH(BANK_DEPTH)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (bank_en[b]),
      .we   (req_write),
      .idx  (bank_offset[IDX_W-1:0]),
      .wbyte(wbyte),
      .rbyte(bank_q[b*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_err_range <= 1'b0;
      rsp_err_align <= 1'b0;
      sel_q         <= '0;
      wide_q        <= 1'b0;
      read_q        <= 1'b0;
    end else if (fire) begin
      rsp_valid     <= 1'b1;
      rsp_err_range <= (kind == ACC_BAD_RANGE);
      rsp_err_align <= (kind == ACC_BAD_ALIGN);
      sel_q         <= req_addr[SEL_W-1:0];
      wide_q        <= req_wide;
      read_q        <= !req_write && (kind == ACC_BYTE || kind == ACC_WIDE);
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  ilv_gather #(.NUM_BANKS(NUM_BANKS), .LANES(LANES)) u_gather (
    .bank_q(bank_q),
    .sel_q (sel_q),
    .wide_q(wide_q),
    .read_q(read_q),
    .rdata (rsp_rdata)
  );

  assert_resp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) &&
                                   $stable(rsp_err_range) && $stable(rsp_err_align)));
  assert_errors_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_err_range && rsp_err_align));
  assert_error_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_err_range || rsp_err_align)) |-> (rsp_rdata == '0));
endmodule

// File: tb/byte_bank_interleaver_test.sv
module byte_bank_interleaver_test;
  localparam int NB = 64;
  localparam int DEP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic        rsp_err_range;
  logic        rsp_err_align;
  logic [63:0] bank_en;
  logic        bank_we;
  logic [21:0] bank_offset;

  always #10 clk = ~clk;

  byte_bank_interleaver uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wide(req_wide), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err_range(rsp_err_range), .rsp_err_align(rsp_err_align),
    .bank_en(bank_en), .bank_we(bank_we), .bank_offset(bank_offset)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cur_fire = 0;
  bit stall_mode = 0;
  int cyc = 0;

  // reference model state
  logic [7:0]  mem_m [NB*DEP];
  bit          m_valid = 0;
  logic [63:0] m_rdata = '0;
  bit          m_erange = 0;
  bit          m_ealign = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int midx(input int bank, input logic [31:0] a);
    return bank * DEP + int'(a[9:6]);
  endfunction

  // checker and model: evaluate before each rising edge, update after it
  initial begin
    for (int i = 0; i < NB*DEP; i++) mem_m[i] = 8'h00;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        bit rdy, fire, rng, alg;
        logic [63:0] exp_en;
        int base;
        string tag;
        cyc++;
        rdy  = !m_valid || rsp_ready;
        fire = req_valid && rdy;
        rng  = req_addr[31:28] != 4'h0;
        alg  = req_wide && req_addr[2:0] != 3'b0 && !rng;
        base = int'(req_addr[5:0]);
        exp_en = '0;
        tag = "R6";
        if (fire) begin
          if (rng) tag = "R1";
          else if (alg) tag = "R5";
          else if (req_wide) begin
            tag = "R4";
            for (int k = 0; k < 8; k++) exp_en[base+k] = 1'b1;
          end else begin
            tag = "R3";
            exp_en[base] = 1'b1;
          end
        end
        chk("R8", "req_ready", 64'(req_ready), 64'(rdy));
        chk(tag, "bank_en", bank_en, exp_en);
        if (exp_en != '0) begin
          chk("R2", "bank_offset", 64'(bank_offset), 64'(req_addr[27:6]));
          chk(tag, "bank_we", 64'(bank_we), 64'(req_write));
        end
        chk("R7", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
        if (m_valid) begin
          chk("R7", "rsp_rdata", rsp_rdata, m_rdata);
          chk("R1", "rsp_err_range", 64'(rsp_err_range), 64'(m_erange));
          chk("R5", "rsp_err_align", 64'(rsp_err_align), 64'(m_ealign));
        end
        cur_fire = fire;
        @(posedge clk);
        if (fire) begin
          m_valid = 1; m_erange = rng; m_ealign = alg; m_rdata = '0;
          if (!rng && !alg) begin
            for (int k = 0; k < (req_wide ? 8 : 1); k++) begin
              int id;
              id = midx(base + k, req_addr);
              if (req_write) mem_m[id] = req_req_byte(k);
              else m_rdata[8*k +: 8] = mem_m[id];
            end
          end
        end else if (rsp_ready) begin
          m_valid = 0;
        end
      end else begin
        cur_fire = 0;
      end
    end
  end

  function automatic logic [7:0] req_req_byte(input int k);
    return req_wdata[8*k +: 8];
  endfunction

  // response back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready <= stall_mode ? ((cyc % 5) != 3 && (cyc % 7) != 2) : 1'b1;
    end
  end

  task automatic send(input logic [31:0] a, input bit wr, input bit wd,
                      input logic [63:0] wdat);
    @(negedge clk);
    req_valid <= 1'b1; req_addr <= a; req_write <= wr; req_wide <= wd; req_wdata <= wdat;
    do @(posedge clk); while (!cur_fire);
    @(negedge clk);
    req_valid <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    chk("R9", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n <= 1'b1;
    idle(2);
    // R9: fresh contents read zero
    send(32'h0000_0000, 0, 1, '0);
    send(32'h0000_03F8, 0, 1, '0);
    // R3: single bytes at bank edges
    send(32'h0000_0000, 1, 0, 64'hA1);
    send(32'h0000_0001, 1, 0, 64'hFFFF_FFFF_FFFF_FFB2);
    send(32'h0000_003F, 1, 0, 64'hC3);
    send(32'h0000_0040, 1, 0, 64'hD4);
    send(32'h0000_007F, 1, 0, 64'hE5);
    send(32'h0000_003F, 0, 0, '0);
    send(32'h0000_0001, 0, 0, '0);
    send(32'h0000_0040, 0, 1, '0);
    // R4: wide at top group and bank 0
    send(32'h0000_0038, 1, 1, 64'h8877_6655_4433_2211);
    send(32'h0000_0080, 1, 1, 64'h0F0E_0D0C_0B0A_0908);
    send(32'h0000_0038, 0, 1, '0);
    send(32'h0000_003A, 0, 0, '0);
    send(32'h0000_0087, 0, 0, '0);
    send(32'h0000_0080, 0, 1, '0);
    // R5: misaligned wide write must not land
    send(32'h0000_0083, 1, 1, 64'hDEAD_BEEF_DEAD_BEEF);
    send(32'h0000_0080, 0, 1, '0);
    // R1: out of range, including both faults at once
    send(32'h1000_0000, 1, 0, 64'h77);
    send(32'hF000_0085, 1, 1, 64'h1234);
    send(32'h0000_0000, 0, 0, '0);
    // R2: alias one wrap apart in the modelled bank
    send(32'h0000_0005, 1, 0, 64'h5A);
    send(32'h0000_0405, 0, 0, '0);
    send(32'h0BC0_0405, 0, 0, '0);
    // R8: back-pressure with back-to-back traffic
    stall_mode = 1;
    begin
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 300; n++) begin
        logic [31:0] a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        a = {(lf[31:29] == 3'b111) ? lf[27:24] : 4'h0, 18'h0, lf[9:0]};
        if (lf[12]) a[2:0] = lf[13] ? 3'b000 : a[2:0];
        send(a, lf[15], lf[12], {lf, ~lf});
      end
    end
    stall_mode = 0;
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule